// File: doc/BRIEF.md
# CPU Slot Rotating Bus Arbiter

This block decides which requester owns a single shared bus next. The requesters are one host processor and a parameterised set of peripheral masters. The peripheral masters share the bus in rotating order. The processor is promised a slot once a programmable count of peripheral transactions has finished. That count, N, is 1, 2 or 3 and is chosen by a two-bit setting. A small N gives the processor low latency. A large N gives the peripherals more of the bus.

Ownership changes only at arbitration points. An arbitration point is any cycle in which the bus is unowned, or any cycle in which the current owner pulses the done strobe. At each such point the arbiter registers the next grant, so the new grant appears one clock later. Bus protocol signalling, parking and latency timers belong to other blocks.

Top module: `cpu_slot_arbiter`

## Requirements
- R1: After reset no grant is asserted. The peripheral grant count is zero. The first peripheral search starts at peripheral 0.
- R2: The setting `slot_sel` maps to N as follows: 2'b01 gives 1, 2'b10 gives 2, 2'b11 gives 3. The value 2'b00 is treated as 1.
- R3: A grant, once asserted, stays unchanged until the owner pulses `done`. The next grant appears on the clock edge that follows the arbitration point.
- R4: At most one grant (processor or any peripheral) is asserted in any cycle.
- R5: Peripherals are chosen in round-robin order. The search starts at the index after the last granted peripheral and skips peripherals that are not requesting.
- R6: At an arbitration point, a requesting processor wins if N or more peripheral grants have been issued since its last slot.
- R7: The count of peripheral grants is cleared when the processor is granted and stops rising at N. A processor that raises its request late therefore waits behind at most the owner's current transaction.
- R8: A requesting processor is granted at the next arbitration point whenever no peripheral is requesting, whatever the count.
- R9: The rotation position is kept across processor slots. The peripheral after a processor slot is the one that follows the peripheral granted before it.
- R10: If nothing is requesting at an arbitration point, the bus becomes unowned and no grant is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_sel | input | 2 | Selects N, the number of peripheral grants per processor slot |
| cpu_req | input | 1 | Processor request |
| per_req | input | NP | Peripheral requests, one bit per master |
| done | input | 1 | Transaction-complete strobe from the current owner |
| cpu_gnt | output | 1 | Processor grant |
| per_gnt | output | NP | Peripheral grants, one-hot or zero |

## Verification
The bench drives long queues with the processor requesting all the time for each value of N. A wrong threshold would show up as the processor slot falling one grant early or late. A wrong pointer update would show up as a peripheral being granted again or skipped after a processor slot. The bench also raises the processor request late, after the count has saturated. A counter that kept rising past N or was never cleared would either starve the processor or give it back-to-back slots. Other tests drop all requests while a grant is held, set a sparse request mask, and have the processor request alone. These catch a grant that is dropped before `done`, a rotation that does not skip idle masters, and a processor kept waiting for peripherals that are not there.

// File: rtl/arb_pkg.sv
package arb_pkg;
  // Width of the slot count and of N.
  localparam int CNT_W = 2;

  // Setting to N: 01->1, 10->2, 11->3, 00 falls back to 1.
  function automatic logic [CNT_W-1:0] sel_to_n(input logic [1:0] sel);
    return (sel == 2'b00) ? CNT_W'(1) : CNT_W'(sel);
  endfunction

  // True when the processor's slot is owed.
  function automatic logic slot_owed(input logic [CNT_W-1:0] cnt,
                                     input logic [CNT_W-1:0] n);
    return cnt >= n;
  endfunction
endpackage

// File: rtl/rr_picker.sv
module rr_picker #(
  parameter int NP = 4,
  localparam int IW = (NP > 1) ? $clog2(NP) : 1
) (
  input  logic [NP-1:0] req,
  input  logic [IW-1:0] start,
  output logic          found,
  output logic [IW-1:0] idx
);
  // Search from start upward, wrapping, for the first request.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int k = 0; k < NP; k++) begin
      int j;
      j = (int'(start) + k) % NP;
      if (!found && req[j]) begin
        found = 1'b1;
        idx   = IW'(j);
      end
    end
  end
endmodule

// File: rtl/slot_counter.sv
module slot_counter
  import arb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] n_val,
  input  logic             per_ev,
  input  logic             cpu_ev,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n)                    cnt <= '0;
    else if (cpu_ev)               cnt <= '0;
    else if (per_ev && cnt < n_val) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/cpu_slot_arbiter.sv
module cpu_slot_arbiter
  import arb_pkg::*;
#(
  parameter int NP = 4,
  localparam int IW = (NP > 1) ? $clog2(NP) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    slot_sel,
  input  logic          cpu_req,
  input  logic [NP-1:0] per_req,
  input  logic          done,
  output logic          cpu_gnt,
  output logic [NP-1:0] per_gnt
);
  logic             cpu_gnt_q;
  logic [NP-1:0]    per_gnt_q;
  logic [IW-1:0]    next_ptr;
  logic [CNT_W-1:0] n_val;
  logic [CNT_W-1:0] slot_cnt;
  logic             bus_busy;
  logic             arb_point;
  logic             rr_found;
  logic [IW-1:0]    rr_idx;
  logic             cpu_due;
  logic             pick_cpu;
  logic             pick_per;
  logic [NP-1:0]    per_onehot;

  assign n_val     = sel_to_n(slot_sel);
  assign bus_busy  = cpu_gnt_q | (|per_gnt_q);
  assign arb_point = !bus_busy || done;

  rr_picker #(.NP(NP)) u_pick (
    .req   (per_req),
    .start (next_ptr),
    .found (rr_found),
    .idx   (rr_idx)
  );

  assign cpu_due  = cpu_req && (slot_owed(slot_cnt, n_val) || !rr_found);
  assign pick_cpu = arb_point && cpu_due;
  assign pick_per = arb_point && !cpu_due && rr_found;

  for (genvar g = 0; g < NP; g++) begin : g_onehot
    assign per_onehot[g] = pick_per && (rr_idx == IW'(g));
  end

  slot_counter u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .n_val  (n_val),
    .per_ev (pick_per),
    .cpu_ev (pick_cpu),
    .cnt    (slot_cnt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cpu_gnt_q <= 1'b0;
      per_gnt_q <= '0;
      next_ptr  <= '0;
    end else if (arb_point) begin
      cpu_gnt_q <= pick_cpu;
      per_gnt_q <= per_onehot;
      if (pick_per)
        next_ptr <= (rr_idx == IW'(NP-1)) ? '0 : rr_idx + 1'b1;
    end
  end

  assign cpu_gnt = cpu_gnt_q;
  assign per_gnt = per_gnt_q;
endmodule

// File: rtl/arb_checker.sv
module arb_checker
  import arb_pkg::*;
#(
  parameter int NP = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cpu_req,
  input logic [NP-1:0]    per_req,
  input logic             done,
  input logic             cpu_gnt,
  input logic [NP-1:0]    per_gnt,
  input logic             arb_point,
  input logic [CNT_W-1:0] slot_cnt,
  input logic [CNT_W-1:0] n_val
);
  logic owned;
  assign owned = cpu_gnt | (|per_gnt);

  // R4
  single_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cpu_gnt, per_gnt}));

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (owned && !done) |=> $stable({cpu_gnt, per_gnt}));

  // R6
  cpu_owed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_point && cpu_req && slot_cnt >= n_val) |=> cpu_gnt);

  // R8
  cpu_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_point && cpu_req && per_req == '0) |=> cpu_gnt);

  // R7
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_gnt) |-> slot_cnt == '0);

  // R10
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_point && !cpu_req && per_req == '0) |=> !owned);
endmodule

bind cpu_slot_arbiter arb_checker #(.NP(NP)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cpu_req   (cpu_req),
  .per_req   (per_req),
  .done      (done),
  .cpu_gnt   (cpu_gnt),
  .per_gnt   (per_gnt),
  .arb_point (arb_point),
  .slot_cnt  (slot_cnt),
  .n_val     (n_val)
);

// File: tb/tb_cpu_slot_arbiter.sv
`timescale 1ns/1ps
module tb_cpu_slot_arbiter;
  localparam int NP = 4;
  localparam logic [4:0] C  = 5'b10000;
  localparam logic [4:0] NO = 5'b00000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    slot_sel = 2'b01;
  logic          cpu_req = 1'b0;
  logic [NP-1:0] per_req = '0;
  logic          done = 1'b0;
  logic          cpu_gnt;
  logic [NP-1:0] per_gnt;
  int            n_chk = 0;
  int            n_bad = 0;
  bit            finished = 1'b0;

  always #4 clk = ~clk;

  cpu_slot_arbiter #(.NP(NP)) dut (
    .clk(clk), .rst_n(rst_n), .slot_sel(slot_sel), .cpu_req(cpu_req),
    .per_req(per_req), .done(done), .cpu_gnt(cpu_gnt), .per_gnt(per_gnt)
  );

  function automatic logic [4:0] P(input int i);
    return 5'b00001 << i;
  endfunction

  task automatic chk(input string tag, input logic [4:0] exp);
    logic [4:0] act;
    act = {cpu_gnt, per_gnt};
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: grants actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] sel);
    @(negedge clk);
    rst_n = 1'b0; cpu_req = 1'b0; per_req = '0; done = 1'b0; slot_sel = sel;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Owner pulses done; new grant is sampled one cycle later.
  task automatic finish_owner();
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
  endtask

  task automatic t_reset();
    do_reset(2'b01);
    chk("R1 no grant after reset", NO);
    @(negedge clk);
    chk("R1 idle with no requests", NO);
  endtask

  task automatic t_n1_all();
    do_reset(2'b01);
    per_req = 4'b1111; cpu_req = 1'b1;
    @(negedge clk);
    chk("R1 first peripheral is P0", P(0));
    finish_owner(); chk("R6 N=1 processor after one", C);
    finish_owner(); chk("R9 rotation kept, P1", P(1));
    finish_owner(); chk("R6 N=1 processor again", C);
    finish_owner(); chk("R5 next peripheral P2", P(2));
  endtask

  task automatic t_n3_all();
    do_reset(2'b11);
    per_req = 4'b1111; cpu_req = 1'b1;
    @(negedge clk);
    chk("R2 N=3 P0", P(0));
    finish_owner(); chk("R2 N=3 P1", P(1));
    finish_owner(); chk("R2 N=3 P2", P(2));
    finish_owner(); chk("R6 N=3 processor slot", C);
    finish_owner(); chk("R9 P3 after slot", P(3));
    finish_owner(); chk("R5 wrap to P0", P(0));
    finish_owner(); chk("R5 P1", P(1));
    finish_owner(); chk("R7 count cleared, slot after three", C);
  endtask

  task automatic t_n2_late();
    do_reset(2'b10);
    per_req = 4'b1111;
    @(negedge clk);
    chk("R5 P0", P(0));
    finish_owner(); chk("R5 P1", P(1));
    finish_owner(); chk("R5 P2", P(2));
    finish_owner(); chk("R5 P3", P(3));
    cpu_req = 1'b1;
    @(negedge clk);
    chk("R3 P3 held while no done", P(3));
    finish_owner(); chk("R7 late request served at once", C);
    finish_owner(); chk("R9 P0 after slot", P(0));
    finish_owner(); chk("R2 N=2 P1", P(1));
    finish_owner(); chk("R6 N=2 processor slot", C);
  endtask

  task automatic t_cpu_alone();
    do_reset(2'b11);
    cpu_req = 1'b1;
    @(negedge clk);
    chk("R8 processor alone granted from idle", C);
    cpu_req = 1'b0; per_req = 4'b0100;
    @(negedge clk);
    chk("R3 processor held until done", C);
    finish_owner(); chk("R5 P2 after processor", P(2));
    cpu_req = 1'b1; per_req = 4'b0000;
    finish_owner(); chk("R8 processor with no peripheral, count 1<3", C);
  endtask

  task automatic t_hold_idle();
    do_reset(2'b01);
    per_req = 4'b0001;
    @(negedge clk);
    chk("R3 P0 granted", P(0));
    per_req = '0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R3 grant held with requests gone", P(0));
    end
    finish_owner(); chk("R10 bus idle after done", NO);
    @(negedge clk);
    chk("R10 stays idle", NO);
  endtask

  task automatic t_sparse();
    do_reset(2'b11);
    per_req = 4'b1010;
    @(negedge clk);
    chk("R5 skip P0, grant P1", P(1));
    finish_owner(); chk("R5 skip P2, grant P3", P(3));
    finish_owner(); chk("R5 wrap skip P0, grant P1", P(1));
  endtask

  task automatic t_sel0();
    do_reset(2'b00);
    per_req = 4'b1111; cpu_req = 1'b1;
    @(negedge clk);
    chk("R2 sel 00 P0", P(0));
    finish_owner(); chk("R2 sel 00 acts as N=1", C);
  endtask

  initial begin
    t_reset();
    t_n1_all();
    t_n3_all();
    t_n2_late();
    t_cpu_alone();
    t_hold_idle();
    t_sparse();
    t_sel0();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule